// File: doc/BRIEF.md
# Logic Block Structural Test Sequencer

This block runs the structural test of one logic block that has been taken out of service. The block under test has two slices. A session goes through six fixed test phases. Before each phase the sequencer asks for the block under test to be put into that phase's configuration, using one request/acknowledge handshake. It then applies that phase's vectors. Each vector is generated inside the sequencer and sent one bit at a time into a 13-cell user test register. Every cell has a serial stage and a held output stage. The held outputs feed the same 13 inputs of both slices in parallel.

After each vector has been applied and allowed to settle, the sequencer captures six response bits from each slice. It checks each slice against its own expected value. A mismatch sets a per-slice failure flag that stays set for the rest of the session, so a fault is traced to one slice. The serial output shows the serial stage, so the previous vector comes back out while the next one is shifted in. This gives a loopback check of the register.

Top module: `lbst_seq`

## Requirements
- R1: After reset, all of these outputs are low: `busy`, `done`, `fail`, `cfg_req`, `shift_o`, `update_o`, `vec_out` and `tdo`.
- R2: A session runs phases 0 to 5 in that order, with 16, 16, 2, 2, 2 and 2 vectors. `cfg_phase` gives the phase being requested.
- R3: The register has 13 cells. While `shift_o` is high, the serial stage shifts one place toward cell 0 and takes the new bit into cell 12. `vec_out` changes only on the clock edge that ends an `update_o` cycle. At that edge it copies the whole serial stage.
- R4: Each vector takes exactly 13 shift cycles, then one update cycle, then one settle cycle, then one sample cycle. The responses are judged on the clock edge that ends the sample cycle.
- R5: At the start of every phase, `cfg_req` rises and stays high until a cycle with `cfg_ack` high. No shifting takes place while `cfg_req` is high. The wait may be of any length.
- R6: Vector `i` of phases 0 and 1 sets bit 12 to `i[0]` and bit `k` (k < 12) to `i[k mod 4]`. The two vectors of each of phases 2 to 5 are 13'h0555 and then 13'h1AAA. Bits are shifted in starting with bit 0.
- R7: Slice s answers on `resp_in[6s+5:6s]`. Expected bit k (k < 6) is `v[k] ^ v[k+6] ^ v[12]`, where v is the applied vector. In odd phases every expected bit is inverted. `fail[s]` is set only by a mismatch in slice s.
- R8: Failure flags stay set until the session ends. They are cleared only when a new session is started.
- R9: `tdo` shows serial cell 0. During the 13 shift cycles of a vector, `tdo` gives the previously applied vector, bit 0 first.
- R10: A `start` pulse while `busy` is high has no effect on the phase order or on the failure flags.
- R11: After the final sample, `done` goes high and `busy` goes low. Both stay that way, with `vec_out` held, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a session while the block is idle or done |
| cfg_ack | input | 1 | Acknowledges that the requested phase configuration is in place |
| resp_in | input | 12 | Responses; slice 0 in [5:0], slice 1 in [11:6] |
| cfg_req | output | 1 | Asks for the phase configuration given by cfg_phase |
| cfg_phase | output | 3 | Phase being requested or run |
| shift_o | output | 1 | Shift strobe of the user test register |
| update_o | output | 1 | Update strobe of the user test register |
| tdo | output | 1 | Serial output, serial-stage cell 0 |
| vec_out | output | 13 | Held vector applied to both slices |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished |
| fail | output | 2 | Sticky per-slice failure flags |

## Verification
The old vector leaving on `tdo` and the new vector entering the serial stage happen on the same 13 shift cycles. The bench records `tdo` on every shift cycle and compares the captured word with the vector it last saw on `vec_out`. In the same update cycle it checks that `vec_out` has not yet moved. A second overlap is a `start` pulse arriving while a session is running, after a slice has already been marked failing. The bench sends that pulse in the middle of phase 2. It then judges that the phase order runs on without a break and that the flag is still set at the end.

// File: rtl/lbst_pkg.sv
package lbst_pkg;
  localparam int unsigned VEC_W       = 13;
  localparam int unsigned SLICES      = 2;
  localparam int unsigned RSP_W       = 6;
  localparam int unsigned NPHASE      = 6;
  localparam int unsigned LONG_PHASES = 2;
  localparam int unsigned LONG_LEN    = 16;
  localparam int unsigned SHORT_LEN   = 2;
  localparam int unsigned PH_W        = $clog2(NPHASE);
  localparam int unsigned IDX_W       = $clog2(LONG_LEN);
  localparam int unsigned BIT_W       = $clog2(VEC_W);
  localparam logic [VEC_W-1:0] SHORT_PAT = 13'h0555;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_SHIFT, ST_UPD, ST_SETTLE, ST_SAMP, ST_DONE
  } seq_st_e;

  function automatic int unsigned phase_len(input logic [PH_W-1:0] p);
    return (int'(p) < LONG_PHASES) ? LONG_LEN : SHORT_LEN;
  endfunction

  function automatic logic [VEC_W-1:0] gen_vec(input logic [PH_W-1:0] p,
                                               input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    if (int'(p) < LONG_PHASES) begin
      for (int k = 0; k < VEC_W - 1; k++) v[k] = idx[k % IDX_W];
      v[VEC_W-1] = idx[0];
    end else begin
      v = idx[0] ? ~SHORT_PAT : SHORT_PAT;
    end
    return v;
  endfunction

  function automatic logic [RSP_W-1:0] exp_slice(input logic [PH_W-1:0] p,
                                                 input logic [VEC_W-1:0] v);
    logic [RSP_W-1:0] r;
    for (int k = 0; k < RSP_W; k++) r[k] = v[k] ^ v[k+RSP_W] ^ v[VEC_W-1];
    return p[0] ? ~r : r;
  endfunction
endpackage

// File: rtl/lbst_vreg.sv
module lbst_vreg #(
  parameter int unsigned W = lbst_pkg::VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         upd,
  input  logic         tdi,
  output logic         tdo,
  output logic [W-1:0] vec
);
  logic [W-1:0] sh_q;
  logic [W-1:0] up_q;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic nxt_bit;
    if (i == W - 1) begin : g_top
      assign nxt_bit = tdi;
    end else begin : g_mid
      assign nxt_bit = sh_q[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q[i] <= 1'b0;
        up_q[i] <= 1'b0;
      end else begin
        if (shift) sh_q[i] <= nxt_bit;
        if (upd)   up_q[i] <= sh_q[i];
      end
    end
  end

  assign tdo = sh_q[0];
  assign vec = up_q;

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(vec)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && upd)); // R3
endmodule

// File: rtl/lbst_judge.sv
module lbst_judge #(
  parameter int unsigned NS = lbst_pkg::SLICES,
  parameter int unsigned RW = lbst_pkg::RSP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           sample,
  input  logic [RW-1:0]  expect_bits,
  input  logic [NS*RW-1:0] resp,
  output logic [NS-1:0]  fail
);
  logic [NS-1:0] mism;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    assign mism[s] = resp[s*RW +: RW] != expect_bits;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fail[s] <= 1'b0;
      else if (clr)              fail[s] <= 1'b0;
      else if (sample && mism[s]) fail[s] <= 1'b1;
    end
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fail[s] && !clr |=> fail[s]); // R8
    AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !fail[s] && !(sample && mism[s]) |=> !fail[s]); // R7
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> fail == '0); // R8
endmodule

// File: rtl/lbst_ctrl.sv
module lbst_ctrl
  import lbst_pkg::*;
#(
  parameter int unsigned W  = VEC_W,
  parameter int unsigned NP = NPHASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_ack,
  output logic             cfg_req,
  output logic [PH_W-1:0]  phase,
  output logic             shift,
  output logic             upd,
  output logic             sample,
  output logic             clr,
  output logic             tdi,
  output logic             busy,
  output logic             done
);
  seq_st_e            st_q;
  logic [IDX_W-1:0]   vidx_q;
  logic [BIT_W-1:0]   bit_q;
  logic [W-1:0]       cur_vec;
  logic               last_bit;
  logic               last_vec;
  logic               last_phase;

  assign cur_vec    = gen_vec(phase, vidx_q);
  assign tdi        = cur_vec[bit_q];
  assign last_bit   = int'(bit_q) == W - 1;
  assign last_vec   = int'(vidx_q) == int'(phase_len(phase)) - 1;
  assign last_phase = int'(phase) == NP - 1;
  assign clr        = start && (st_q == ST_IDLE || st_q == ST_DONE);

  assign cfg_req = st_q == ST_REQ;
  assign shift   = st_q == ST_SHIFT;
  assign upd     = st_q == ST_UPD;
  assign sample  = st_q == ST_SAMP;
  assign done    = st_q == ST_DONE;
  assign busy    = !(st_q == ST_IDLE || st_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      phase  <= '0;
      vidx_q <= '0;
      bit_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: if (clr) begin
          st_q   <= ST_REQ;
          phase  <= '0;
          vidx_q <= '0;
          bit_q  <= '0;
        end
        ST_REQ: if (cfg_ack) begin
          st_q  <= ST_SHIFT;
          bit_q <= '0;
        end
        ST_SHIFT: begin
          bit_q <= bit_q + 1'b1;
          if (last_bit) st_q <= ST_UPD;
        end
        ST_UPD:    st_q <= ST_SETTLE;
        ST_SETTLE: st_q <= ST_SAMP;
        ST_SAMP: begin
          bit_q <= '0;
          if (last_vec) begin
            vidx_q <= '0;
            if (last_phase) st_q <= ST_DONE;
            else begin
              phase <= phase + 1'b1;
              st_q  <= ST_REQ;
            end
          end else begin
            vidx_q <= vidx_q + 1'b1;
            st_q   <= ST_SHIFT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req); // R5
  AST_NO_SHIFT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !shift); // R5
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_req, shift, upd, sample})); // R4
  AST_UPD_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(shift)); // R4
  AST_SAMP_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> $past(upd, 2)); // R4
  AST_PHASE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sample |=> $stable(phase)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R11
endmodule

// File: rtl/lbst_seq.sv
module lbst_seq
  import lbst_pkg::*;
#(
  parameter int unsigned W  = VEC_W,
  parameter int unsigned NS = SLICES,
  parameter int unsigned RW = RSP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_ack,
  input  logic [NS*RW-1:0]  resp_in,
  output logic              cfg_req,
  output logic [PH_W-1:0]   cfg_phase,
  output logic              shift_o,
  output logic              update_o,
  output logic              tdo,
  output logic [W-1:0]      vec_out,
  output logic              busy,
  output logic              done,
  output logic [NS-1:0]     fail
);
  logic          sample_w;
  logic          clr_w;
  logic          tdi_w;
  logic [RW-1:0] exp_w;

  lbst_ctrl #(.W(W), .NP(NPHASE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ack(cfg_ack),
    .cfg_req(cfg_req), .phase(cfg_phase), .shift(shift_o), .upd(update_o),
    .sample(sample_w), .clr(clr_w), .tdi(tdi_w), .busy(busy), .done(done)
  );

  lbst_vreg #(.W(W)) vreg_i (
    .clk(clk), .rst_n(rst_n), .shift(shift_o), .upd(update_o),
    .tdi(tdi_w), .tdo(tdo), .vec(vec_out)
  );

  assign exp_w = exp_slice(cfg_phase, vec_out);

  lbst_judge #(.NS(NS), .RW(RW)) judge_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .sample(sample_w),
    .expect_bits(exp_w), .resp(resp_in), .fail(fail)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R1
endmodule

// File: tb/lbst_seq_tb_top.sv
module lbst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_ack = 1'b0;
  logic [11:0] resp_in;
  logic        cfg_req, shift_o, update_o, tdo, busy, done;
  logic [2:0]  cfg_phase;
  logic [12:0] vec_out;
  logic [1:0]  fail;

  int checks = 0, errs = 0;
  int bph = 0, fph = 7, vcount = 0, shcnt = 0;
  logic [5:0]  f0 = '0, f1 = '0;
  logic [12:0] cap = '0, prev = '0;
  bit mon_en = 0, pend = 0, finished = 0;

  always #5 clk = ~clk;

  function automatic logic [12:0] bgen(int p, int i);
    logic [12:0] v;
    if (p < 2) begin
      for (int k = 0; k < 12; k++) v[k] = i[k % 4];
      v[12] = i[0];
    end else v = (i == 0) ? 13'h0555 : 13'h1AAA;
    return v;
  endfunction

  function automatic logic [5:0] bexp(int p, logic [12:0] v);
    logic [5:0] r;
    for (int k = 0; k < 6; k++) r[k] = v[k] ^ v[k+6] ^ v[12];
    return (p % 2 == 1) ? ~r : r;
  endfunction

  function automatic int blen(int p);
    return (p < 2) ? 16 : 2;
  endfunction

  assign resp_in = {bexp(bph, vec_out) ^ ((bph == fph) ? f1 : 6'd0),
                    bexp(bph, vec_out) ^ ((bph == fph) ? f0 : 6'd0)};

  lbst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ack(cfg_ack),
    .resp_in(resp_in), .cfg_req(cfg_req), .cfg_phase(cfg_phase),
    .shift_o(shift_o), .update_o(update_o), .tdo(tdo), .vec_out(vec_out),
    .busy(busy), .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: shift count, loopback word, applied vector
  always @(negedge clk) if (mon_en) begin
    if (shift_o) begin
      if (shcnt < 13) cap[shcnt] = tdo;
      shcnt++;
    end
    if (update_o) begin
      chk(shcnt == 13, "R4 shift cycles per vector", shcnt, 13);
      chk(cap == prev, "R9 tdo returns previous vector", cap, prev);
      chk(vec_out == prev, "R3 vec_out held until update", vec_out, prev);
      shcnt = 0;
      pend = 1;
    end else if (pend) begin
      chk(vec_out == bgen(bph, vcount), "R6 applied vector", vec_out, bgen(bph, vcount));
      prev = vec_out;
      vcount++;
      pend = 0;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_session(input int fault_ph, input logic [5:0] m0,
                             input logic [5:0] m1, input logic [1:0] exp_fail,
                             input bit mid_start, input string tag);
    fph = fault_ph; f0 = m0; f1 = m1;
    pulse_start();
    chk(fail == 2'b00, "R8 flags cleared by start", fail, 0);
    chk(busy == 1'b1, "R11 busy during session", busy, 1);
    for (int p = 0; p < 6; p++) begin
      while (!cfg_req) @(negedge clk);
      chk(cfg_phase == p, "R2 phase order", cfg_phase, p);
      if (p > 0) chk(vcount == blen(p - 1), "R2 vectors per phase", vcount, blen(p - 1));
      bph = p; vcount = 0;
      for (int d = 0; d < ((p == 0) ? 20 : 3); d++) begin
        @(negedge clk);
        chk(cfg_req && !shift_o, "R5 request held without shifting", {cfg_req, shift_o}, 2);
      end
      cfg_ack = 1'b1;
      @(negedge clk) cfg_ack = 1'b0;
      if (mid_start && p == 2) begin
        repeat (5) @(negedge clk);
        pulse_start();
        chk(busy == 1'b1, "R10 start ignored while busy", busy, 1);
      end
    end
    while (!done) @(negedge clk);
    chk(vcount == 2, "R2 vectors in last phase", vcount, 2);
    chk(!busy, "R11 busy low at end", busy, 0);
    chk(fail == exp_fail, tag, fail, exp_fail);
    repeat (3) @(negedge clk);
    chk(done && vec_out == prev, "R11 done and vector held", {done, vec_out}, {1'b1, prev});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, fail, cfg_req, shift_o, update_o, vec_out, tdo} == '0,
        "R1 reset state", {busy, done, fail, cfg_req, shift_o, update_o, vec_out, tdo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fail, cfg_req} == '0, "R1 idle after reset", {busy, done, fail, cfg_req}, 0);
    mon_en = 1;
    run_session(7, 6'd0, 6'd0, 2'b00, 0, "R7 clean block passes");
    run_session(3, 6'd0, 6'h04, 2'b10, 0, "R7 slice 1 fault located");
    run_session(0, 6'h01, 6'd0, 2'b01, 0, "R7 slice 0 fault in long phase");
    run_session(7, 6'd0, 6'd0, 2'b00, 0, "R8 new session clears flags");
    run_session(0, 6'h20, 6'd0, 2'b01, 1, "R10 mid-session start keeps flag");
    run_session(5, 6'h3F, 6'h3F, 2'b11, 0, "R7 both slices faulty");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule